// File: doc/BRIEF.md
# Rotating-Enable Five-Way Redundant Voter

The block computes one multiply-add result on five identical lanes and votes among them, so that a single upset lane does not corrupt the answer. Every lane forms the 64-bit product of two 32-bit operands. Each lane then adds one bit of a fault-injection word, and that bit is different for each lane. An injection-enable input gates the fault word. This lets a test harness disturb chosen lanes on purpose and then confirm that the vote steers around them.

Only three of the five lanes take part in the vote at any time. The voter walks the five neighbouring lane pairs in a fixed circular priority. It accepts the first pair whose two lanes are both enabled and whose results agree. It reports that pair's result together with a two-digit diagnosis code. When the diagnosis differs from the one produced on the previous accepted input, the enable pattern moves by one lane around the ring. The participating lanes therefore drift whenever the fault picture changes. Result and diagnosis appear one clock after an input is presented.

Top module: `penta_vote`

## Requirements
- R1: Lane k (k = 1..5) produces in_op_a × in_op_b + (effective fault word AND mask_k) as a 64-bit value. The masks are 16, 8, 4, 2 and 1 for lanes 1 to 5, which means in_fault bit 4 reaches lane 1 and in_fault bit 0 reaches lane 5.
- R2: The voter tests the lane pairs in the priority order (1,2), (2,3), (3,4), (4,5), (5,1). The first pair whose lanes are both enabled and whose results are equal wins. The diagnosis is the unsigned 8-bit binary value 12, 23, 34, 45 or 51 for the respective winning pair. The result taken is that of the first-named lane of the pair, so lane 5 supplies it for code 51.
- R3: When no pair qualifies, the result is lane 5's value and the diagnosis is 55.
- R4: out_valid is high exactly in the cycle after a cycle with in_valid high. out_result and out_diag take the vote at that same edge and hold their values while in_valid stays low.
- R5: While reset is asserted, out_valid, out_result and out_diag are zero. After reset, lanes 1, 2 and 3 are enabled, lanes 4 and 5 are disabled, and the stored previous diagnosis is 0.
- R6: On an accepted input whose diagnosis differs from the stored previous diagnosis, the enables rotate by one position before the next vote: lane k+1 takes lane k's enable and lane 1 takes lane 5's enable. When the two codes are equal, the enables stay as they are.
- R7: Every accepted input stores its diagnosis as the new previous diagnosis. Cycles with in_valid low change neither the enables nor the stored diagnosis.
- R8: With in_inj_en low, the fault word is treated as zero, so all five lanes are equal whatever in_fault carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands and fault word are presented this cycle |
| in_op_a | input | 32 | First multiplier operand |
| in_op_b | input | 32 | Second multiplier operand |
| in_fault | input | 5 | Fault-injection word; bit 4 goes to lane 1 and bit 0 to lane 5 |
| in_inj_en | input | 1 | Lets the fault word through when high |
| out_valid | output | 1 | Result and diagnosis belong to the previous cycle's input |
| out_result | output | 64 | Voted result |
| out_diag | output | 8 | Diagnosis code: 12, 23, 34, 45, 51 or 55 |

## Verification
The assertions take for granted that the inputs are known, not X, whenever in_valid is high. They also take for granted that the internal reset has settled before the first input arrives. The bench holds in_valid low through reset and for three clocks after release. It drives every input only on falling edges. Each fault word it uses is chosen so that the disturbed lanes differ from the clean product by a known mask value, and the product plus any mask never wraps around the 64-bit width.

// File: rtl/penta_vote_pkg.sv
package penta_vote_pkg;
  localparam int NPATH  = 5;
  localparam int DIAG_W = 8;

  // Diagnosis for the pair starting at zero-based lane i: two decimal digits
  function automatic logic [DIAG_W-1:0] pair_code(input int i);
    return DIAG_W'(10 * (i + 1) + ((i + 1) % NPATH) + 1);
  endfunction

  localparam logic [DIAG_W-1:0] NO_AGREE = DIAG_W'(11 * NPATH);

  // Lanes 1..3 (bits 0..2) enabled after reset
  localparam logic [NPATH-1:0] EN_RESET = NPATH'(7);

  // Enable of lane k moves to lane k+1, last lane wraps to the first
  function automatic logic [NPATH-1:0] rotate_up(input logic [NPATH-1:0] v);
    return {v[NPATH-2:0], v[NPATH-1]};
  endfunction
endpackage

// File: rtl/pv_rst_sync.sv
module pv_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pv_lane.sv
module pv_lane #(
  parameter int OP_W     = 32,
  parameter int RES_W    = 2 * OP_W,
  parameter int MASK_BIT = 0
) (
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             inj_bit,
  output logic [RES_W-1:0] lane_res
);
  logic [RES_W-1:0] product;
  logic [RES_W-1:0] disturb;

  always_comb begin
    product  = RES_W'(op_a) * RES_W'(op_b);
    disturb  = RES_W'(inj_bit) << MASK_BIT;
    lane_res = product + disturb;
  end
endmodule

// File: rtl/pv_voter.sv
module pv_voter
  import penta_vote_pkg::*;
#(
  parameter int RES_W = 64
) (
  input  logic [NPATH-1:0][RES_W-1:0] lane_res,
  input  logic [NPATH-1:0]            lane_en,
  output logic [RES_W-1:0]            vote_res,
  output logic [DIAG_W-1:0]           vote_diag
);
  logic [NPATH-1:0] pair_ok;

  for (genvar i = 0; i < NPATH; i++) begin : g_pair
    localparam int J = (i + 1) % NPATH;
    assign pair_ok[i] = lane_en[i] && lane_en[J] && (lane_res[i] == lane_res[J]);
  end

  // Walk from lowest priority to highest so the first qualifying pair wins
  always_comb begin
    vote_res  = lane_res[NPATH-1];
    vote_diag = NO_AGREE;
    for (int i = NPATH - 1; i >= 0; i--) begin
      if (pair_ok[i]) begin
        vote_res  = lane_res[i];
        vote_diag = pair_code(i);
      end
    end
  end
endmodule

// File: rtl/pv_enable_hub.sv
module pv_enable_hub
  import penta_vote_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [DIAG_W-1:0] cur_code,
  output logic [NPATH-1:0]  lane_en,
  output logic [DIAG_W-1:0] prev_code
);
  logic [NPATH-1:0]  en_q, en_d;
  logic [DIAG_W-1:0] prev_q, prev_d;

  always_comb begin
    en_d   = en_q;
    prev_d = prev_q;
    if (step) begin
      prev_d = cur_code;
      if (cur_code != prev_q) begin
        en_d = rotate_up(en_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RESET;
      prev_q <= '0;
    end else begin
      en_q   <= en_d;
      prev_q <= prev_d;
    end
  end

  assign lane_en   = en_q;
  assign prev_code = prev_q;
endmodule

// File: rtl/penta_vote.sv
module penta_vote
  import penta_vote_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int RES_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op_a,
  input  logic [OP_W-1:0]   in_op_b,
  input  logic [NPATH-1:0]  in_fault,
  input  logic              in_inj_en,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_result,
  output logic [DIAG_W-1:0] out_diag
);
  logic                       rst_sync_n;
  logic [NPATH-1:0]           fault_eff;
  logic [NPATH-1:0][RES_W-1:0] lane_res;
  logic [NPATH-1:0]           hub_en;
  logic [DIAG_W-1:0]          prev_code;
  logic [RES_W-1:0]           vote_res;
  logic [DIAG_W-1:0]          vote_diag;

  logic              vld_q;
  logic [RES_W-1:0]  res_q, res_d;
  logic [DIAG_W-1:0] diag_q, diag_d;

  pv_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign fault_eff = in_inj_en ? in_fault : '0;

  for (genvar i = 0; i < NPATH; i++) begin : g_lane
    pv_lane #(
      .OP_W     (OP_W),
      .RES_W    (RES_W),
      .MASK_BIT (NPATH - 1 - i)
    ) u_lane (
      .op_a     (in_op_a),
      .op_b     (in_op_b),
      .inj_bit  (fault_eff[NPATH-1-i]),
      .lane_res (lane_res[i])
    );
  end

  pv_voter #(.RES_W(RES_W)) u_voter (
    .lane_res  (lane_res),
    .lane_en   (hub_en),
    .vote_res  (vote_res),
    .vote_diag (vote_diag)
  );

  pv_enable_hub u_hub (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (in_valid),
    .cur_code  (vote_diag),
    .lane_en   (hub_en),
    .prev_code (prev_code)
  );

  always_comb begin
    res_d  = res_q;
    diag_d = diag_q;
    if (in_valid) begin
      res_d  = vote_res;
      diag_d = vote_diag;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      diag_q <= '0;
    end else begin
      vld_q  <= in_valid;
      res_q  <= res_d;
      diag_q <= diag_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_diag   = diag_q;
endmodule

// File: rtl/penta_vote_chk.sv
module penta_vote_chk
  import penta_vote_pkg::*;
#(
  parameter int RES_W = 64
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       in_valid,
  input logic                       in_inj_en,
  input logic                       out_valid,
  input logic [RES_W-1:0]           out_result,
  input logic [DIAG_W-1:0]          out_diag,
  input logic [NPATH-1:0][RES_W-1:0] lane_res,
  input logic [NPATH-1:0]           hub_en,
  input logic [DIAG_W-1:0]          prev_code,
  input logic [RES_W-1:0]           vote_res,
  input logic [DIAG_W-1:0]          vote_diag
);
  for (genvar i = 0; i < NPATH; i++) begin : g_pair_chk
    localparam int J = (i + 1) % NPATH;
    // R2
    pair_agree_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (vote_diag == pair_code(i)) |->
        (hub_en[i] && hub_en[J] && lane_res[i] == lane_res[J] && vote_res == lane_res[i]));
    // R8
    gate_equal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_inj_en |-> (lane_res[i] == lane_res[0]));
  end

  // R3
  fallback_lane5_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vote_diag == NO_AGREE) |-> (vote_res == lane_res[NPATH-1]));

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_diag)));

  // R6
  rotate_on_change_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && vote_diag != prev_code) |=> (hub_en == rotate_up($past(hub_en))));

  // R6
  keep_on_same_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && vote_diag == prev_code) |=> $stable(hub_en));

  // R7
  prev_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (prev_code == $past(vote_diag)));

  // R7
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(hub_en) && $stable(prev_code)));

  // R2
  three_enabled_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(hub_en) == 3);
endmodule

bind penta_vote penta_vote_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_inj_en  (in_inj_en),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_diag   (out_diag),
  .lane_res   (lane_res),
  .hub_en     (hub_en),
  .prev_code  (prev_code),
  .vote_res   (vote_res),
  .vote_diag  (vote_diag)
);

// File: tb/penta_vote_bench.sv
`timescale 1ns/1ps
module penta_vote_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_op_a, in_op_b;
  logic [4:0]  in_fault;
  logic        in_inj_en;
  logic        out_valid;
  logic [63:0] out_result;
  logic [7:0]  out_diag;

  int n_checks = 0;
  int n_fails  = 0;

  // reference state, kept from the requirements
  logic [4:0] m_en;
  logic [7:0] m_prev;

  penta_vote u_penta_vote (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op_a    (in_op_a),
    .in_op_b    (in_op_b),
    .in_fault   (in_fault),
    .in_inj_en  (in_inj_en),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_diag   (out_diag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // R1 R2 R3 R6 R7 R8 reference
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [4:0] f,
                       input logic inj, output logic [63:0] er, output logic [7:0] ed);
    logic [63:0] r [5];
    logic [4:0]  fe;
    fe = inj ? f : 5'd0;
    for (int k = 0; k < 5; k++) begin
      r[k] = 64'(a) * 64'(b) + (fe[4-k] ? (64'd1 << (4 - k)) : 64'd0);
    end
    er = r[4];
    ed = 8'd55;
    for (int k = 4; k >= 0; k--) begin
      if (m_en[k] && m_en[(k+1)%5] && r[k] == r[(k+1)%5]) begin
        er = r[k];
        ed = 8'(10 * (k + 1) + ((k + 1) % 5) + 1);
      end
    end
    if (ed != m_prev) m_en = {m_en[3:0], m_en[4]};
    m_prev = ed;
  endtask

  task automatic step(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] f, input logic inj);
    logic [63:0] er;
    logic [7:0]  ed;
    model(a, b, f, inj, er, ed);
    in_op_a = a; in_op_b = b; in_fault = f; in_inj_en = inj; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R4 valid"}, 64'(out_valid), 64'd1);
    check({req, " result"}, out_result, er);
    check({req, " diag"}, 64'(out_diag), 64'(ed));
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R5 reset valid", 64'(out_valid), 64'd0);
    check("R5 reset result", out_result, 64'd0);
    check("R5 reset diag", 64'(out_diag), 64'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_en = 5'b00111;
    m_prev = 8'd0;
  endtask

  // R6: clean inputs walk the enables round the ring, then settle
  task automatic t_walk();
    step("R6 walk 12", 32'd3, 32'd7, 5'd0, 1'b0);
    step("R6 walk 23", 32'd100, 32'd9, 5'd0, 1'b0);
    step("R6 walk 34", 32'hABCD, 32'h1234, 5'd0, 1'b0);
    step("R6 walk 45", 32'd5, 32'd5, 5'd0, 1'b0);
    step("R2 wrap to 12", 32'd11, 32'd13, 5'd0, 1'b0);
    step("R6 same code keeps", 32'd2, 32'd2, 5'd0, 1'b0);
  endtask

  // R4 R7: idle cycles hold outputs and change no voting state
  task automatic t_idle();
    logic [63:0] r0;
    logic [7:0]  d0;
    r0 = out_result; d0 = out_diag;
    in_op_a = 32'hFFFF; in_op_b = 32'h1; in_fault = 5'b11111; in_inj_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 idle valid low", 64'(out_valid), 64'd0);
      check("R4 idle result hold", out_result, r0);
      check("R4 idle diag hold", 64'(out_diag), 64'(d0));
    end
    step("R7 after idle", 32'd6, 32'd7, 5'd0, 1'b0);
  endtask

  // R1 R8: single-lane disturbances and the injection gate
  task automatic t_inject();
    step("R1 lane3 hit", 32'd40, 32'd41, 5'b00100, 1'b1);
    step("R1 lane1 hit", 32'd40, 32'd41, 5'b10000, 1'b1);
    step("R8 gate off", 32'd40, 32'd41, 5'b01000, 1'b0);
    step("R1 lane2 hit", 32'd40, 32'd41, 5'b01000, 1'b1);
  endtask

  // R3: every lane distinct, lane 5 carries mask 1
  task automatic t_fallback();
    step("R3 no agree", 32'd1000, 32'd3, 5'b11111, 1'b1);
    step("R2 pair45", 32'd1000, 32'd3, 5'd0, 1'b1);
  endtask

  // R2: wrap pair chosen, result from lane 5
  task automatic t_pair51();
    step("R2 pair51", 32'd77, 32'd77, 5'b01000, 1'b1);
    step("R2 after 51", 32'd77, 32'd77, 5'd0, 1'b1);
  endtask

  // R1: full-scale operands
  task automatic t_max();
    step("R1 max operands", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1);
    step("R1 max with hits", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b11111, 1'b1);
  endtask

  // R5: reset mid-run restores lanes 1..3 and a zero previous code
  task automatic t_reset_mid();
    do_reset();
    step("R5 first after reset", 32'd9, 32'd9, 5'd0, 1'b0);
    step("R5 second after reset", 32'd9, 32'd9, 5'd0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_op_a = '0; in_op_b = '0; in_fault = '0; in_inj_en = 1'b0;
    m_en = 5'b00111; m_prev = 8'd0;
    @(negedge clk);
    do_reset();
    t_walk();
    t_idle();
    t_inject();
    t_fallback();
    t_pair51();
    t_max();
    t_reset_mid();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule